// File: doc/BRIEF.md
# DMA Descriptor Integrity Checker

This block inspects one DMA descriptor at a time. The descriptor arrives as sixteen 32-bit words on a valid/ready stream, word 0 first, and the block gives a verdict on it in the cycle after the sixteenth word is taken. Word 0 is the control word. Its low byte must be a fixed marker. One control bit turns on an additive checksum held in word 15. The top bit of word 5 is a "done" flag, and it counts as stale unless an override bit in the control word is set.

Besides the verdict, the block builds a per-channel status word from the control flags. It also decodes the line-geometry word (word 3) into a line size, a byte stride and a packed video word. All results stay on the outputs until the first word of the next descriptor is taken. An abort input drops a descriptor that is only partly received. The block does not fetch the words, and it does not act on the verdict.

The stream has no back-pressure: `in_ready` is held high, so every cycle with `in_valid` high moves one word. Idle cycles between words are allowed. `in_data` is only looked at when `in_valid` is high. Words are counted from 0 within the current descriptor.

Top module: `dsc_integrity_checker`

## Requirements
- R1: `in_ready` is always 1. A word is taken on every clock edge where `in_valid` is 1 and `in_abort` is 0. When word 15 is taken, `res_done` is 1 for exactly the following cycle.
- R2: If bits 7:0 of word 0 are not 0xA5, the verdict `res_code` is 1 (bad marker).
- R3: If control bit 20 is 1 and the modulo-2^32 sum of words 0..14 differs from word 15, `res_code` is 2 (bad checksum). If control bit 20 is 0, word 15 has no effect on the verdict.
- R4: If bit 31 of word 5 is 1 and control bit 10 is 0, `res_code` is 3 (already done). If control bit 10 is 1, the flag is ignored. If no check fails, `res_code` is 0.
- R5: The checks are ranked: the marker check first, then the checksum, then the done flag. Only the highest-ranked failure is reported.
- R6: `res_status` has control bits 7:0 at bits 20:13. Bit 4 is control bit 11, bit 5 is control bit 18, bit 6 is control bit 20, bit 7 is control bit 19, bit 8 is control bit 21, bit 9 is control bit 10, bit 10 is word 5 bit 31, bit 11 is control bit 9 and bit 12 is control bit 8. All other bits are 0.
- R7: `res_line_size` is word 3 bits 17:0. `res_line_stride` is word 3 bits 31:18 times 16. `res_video` has word 3 bits 31:18 in bits 13:0 and word 3 bits 17:0 in bits 31:14.
- R8: `res_valid` rises together with `res_done`. All result outputs then hold until word 0 of the next descriptor is taken. In the cycle after that edge, `res_valid` and every result output are 0.
- R9: When `in_abort` is 1 on an edge, the word on the bus is dropped and so is the partial descriptor. No `res_done` comes from it, and the next word taken counts as word 0.
- R10: After reset, `res_done`, `res_valid` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor word present |
| in_ready | output | 1 | Always 1, no back-pressure |
| in_data | input | 32 | Descriptor word |
| in_abort | input | 1 | Drop the partial descriptor |
| res_done | output | 1 | One-cycle pulse: results just became valid |
| res_valid | output | 1 | Results held and valid |
| res_code | output | 2 | Verdict: 0 ok, 1 bad marker, 2 bad checksum, 3 already done |
| res_status | output | 32 | Status word built from control flags |
| res_video | output | 32 | Packed stride units and line size |
| res_line_size | output | 18 | Line size in bytes |
| res_line_stride | output | 18 | Line stride in bytes |

## Verification
The bench builds the block with its defaults: sixteen words, the control word at index 0, geometry at index 3 and the flag word at index 5. With these values every field position named in the requirements can be driven directly. The bench sends descriptors with each single fault and with pairs of faults, to exercise the ranking. It also sends a checksum mismatch with checking disabled, an override of the done flag, idle gaps inside a descriptor, back-to-back descriptors, and an abort part-way through followed by a clean descriptor.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    VERD_OK       = 2'd0,
    VERD_PREAMBLE = 2'd1,
    VERD_SUM      = 2'd2,
    VERD_DONE     = 2'd3
  } verdict_e;

  localparam logic [7:0] MARKER = 8'hA5;

  // control word bit positions
  localparam int C_INTR   = 8;
  localparam int C_UPDATE = 9;
  localparam int C_IGNORE = 10;
  localparam int C_BURST  = 11;
  localparam int C_MODE   = 18;
  localparam int C_LAST   = 19;
  localparam int C_SUMEN  = 20;
  localparam int C_LFRAME = 21;
  localparam int FLAG_BIT = 31;
endpackage

// File: rtl/dsc_word_idx.sv
module dsc_word_idx #(
  parameter int NUM_WORDS = 16,
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             abort,
  output logic [IDX_W-1:0] idx,
  output logic             first,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  assign first = (idx == '0);
  assign last  = (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n)          idx <= '0;
    else if (abort)      idx <= '0;
    else if (beat)       idx <= last ? '0 : idx + 1'b1;
  end

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (idx == '0));
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && last) |=> (idx == '0));
  assert_hold_idx_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat && !abort) |=> $stable(idx));
endmodule

// File: rtl/dsc_sum_acc.sv
module dsc_sum_acc #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              abort,
  input  logic              first,
  input  logic              last,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] sum
);
  // running wrap-around sum of every word before the last one
  always_ff @(posedge clk) begin
    if (!rst_n)                sum <= '0;
    else if (abort)            sum <= '0;
    else if (beat && first)    sum <= data;
    else if (beat && !last)    sum <= sum + data;
  end

  assert_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && first && !abort) |=> (sum == $past(data)));
endmodule

// File: rtl/dsc_word_grab.sv
module dsc_word_grab #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 4,
  parameter int AT     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n)                              word <= '0;
    else if (beat && idx == IDX_W'(AT))      word <= data;
  end
endmodule

// File: rtl/dsc_integrity_checker.sv
module dsc_integrity_checker #(
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 32,
  parameter int CTRL_AT   = 0,
  parameter int LINE_AT   = 3,
  parameter int FLAG_AT   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_abort,
  output logic              res_done,
  output logic              res_valid,
  output logic [1:0]        res_code,
  output logic [31:0]       res_status,
  output logic [31:0]       res_video,
  output logic [17:0]       res_line_size,
  output logic [17:0]       res_line_stride
);
  import dsc_pkg::*;

  localparam int IDX_W = $clog2(NUM_WORDS);
  localparam int NCAP  = 3;
  localparam int CAP_AT [NCAP] = '{CTRL_AT, LINE_AT, FLAG_AT};

  logic              beat;
  logic [IDX_W-1:0]  idx;
  logic              first, last;
  logic [WORD_W-1:0] sum;
  logic [WORD_W-1:0] cap [NCAP];
  logic [WORD_W-1:0] ctrl_w, line_w, flag_w;
  verdict_e          verdict;
  logic [31:0]       status_n;

  assign in_ready = 1'b1;
  assign beat     = in_valid && !in_abort;

  dsc_word_idx #(.NUM_WORDS(NUM_WORDS)) u_idx (
    .clk(clk), .rst_n(rst_n), .beat(beat), .abort(in_abort),
    .idx(idx), .first(first), .last(last)
  );

  dsc_sum_acc #(.WORD_W(WORD_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .beat(beat), .abort(in_abort),
    .first(first), .last(last), .data(in_data), .sum(sum)
  );

  for (genvar g = 0; g < NCAP; g++) begin : g_grab
    dsc_word_grab #(.WORD_W(WORD_W), .IDX_W(IDX_W), .AT(CAP_AT[g])) u_grab (
      .clk(clk), .rst_n(rst_n), .beat(beat), .idx(idx),
      .data(in_data), .word(cap[g])
    );
  end

  assign ctrl_w = cap[0];
  assign line_w = cap[1];
  assign flag_w = cap[2];

  // ranked checks, evaluated while the last word is on the bus
  always_comb begin
    if (ctrl_w[7:0] != MARKER)                          verdict = VERD_PREAMBLE;
    else if (ctrl_w[C_SUMEN] && (sum != in_data))       verdict = VERD_SUM;
    else if (flag_w[FLAG_BIT] && !ctrl_w[C_IGNORE])     verdict = VERD_DONE;
    else                                                verdict = VERD_OK;
  end

  always_comb begin
    status_n         = '0;
    status_n[20:13]  = ctrl_w[7:0];
    status_n[4]      = ctrl_w[C_BURST];
    status_n[5]      = ctrl_w[C_MODE];
    status_n[6]      = ctrl_w[C_SUMEN];
    status_n[7]      = ctrl_w[C_LAST];
    status_n[8]      = ctrl_w[C_LFRAME];
    status_n[9]      = ctrl_w[C_IGNORE];
    status_n[10]     = flag_w[FLAG_BIT];
    status_n[11]     = ctrl_w[C_UPDATE];
    status_n[12]     = ctrl_w[C_INTR];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_done        <= 1'b0;
      res_valid       <= 1'b0;
      res_code        <= '0;
      res_status      <= '0;
      res_video       <= '0;
      res_line_size   <= '0;
      res_line_stride <= '0;
    end else if (beat && last) begin
      res_done        <= 1'b1;
      res_valid       <= 1'b1;
      res_code        <= verdict;
      res_status      <= status_n;
      res_video       <= {line_w[17:0], line_w[31:18]};
      res_line_size   <= line_w[17:0];
      res_line_stride <= {line_w[31:18], 4'b0000};
    end else begin
      res_done <= 1'b0;
      if (beat && first) begin
        res_valid       <= 1'b0;
        res_code        <= '0;
        res_status      <= '0;
        res_video       <= '0;
        res_line_size   <= '0;
        res_line_stride <= '0;
      end
    end
  end

  assert_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);
  assert_done_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> res_valid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !in_valid) |=> ($stable(res_code) && $stable(res_status) && $stable(res_video)));
  assert_marker_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_status[20:13] != MARKER) |-> (res_code == 2'(VERD_PREAMBLE)));
  assert_sum_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && !res_status[6]) |-> (res_code != 2'(VERD_SUM)));
  assert_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_status[9]) |-> (res_code != 2'(VERD_DONE)));
endmodule

// File: tb/sim_dsc_integrity_checker.sv
`timescale 1ns/1ps
module sim_dsc_integrity_checker;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, in_valid, in_abort, in_ready;
  logic [31:0] in_data;
  logic res_done, res_valid;
  logic [1:0] res_code;
  logic [31:0] res_status, res_video;
  logic [17:0] res_line_size, res_line_stride;

  dsc_integrity_checker u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_abort(in_abort), .res_done(res_done),
    .res_valid(res_valid), .res_code(res_code), .res_status(res_status),
    .res_video(res_video), .res_line_size(res_line_size),
    .res_line_stride(res_line_stride)
  );

  int checks = 0, fails = 0;
  typedef logic [31:0] desc_t [16];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] q [$];
  logic        e_done, e_valid;
  logic [1:0]  e_code;
  logic [31:0] e_status, e_video;
  logic [17:0] e_size, e_stride;

  task automatic model_clear();
    e_valid = 0; e_code = 0; e_status = 0; e_video = 0; e_size = 0; e_stride = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); e_done = 0; model_clear();
    end else begin
      e_done = 0;
      if (in_abort) q.delete();
      else if (in_valid) begin
        if (q.size() == 0) model_clear();
        q.push_back(in_data);
        if (q.size() == 16) begin
          logic [31:0] s;
          s = 0;
          for (int i = 0; i < 15; i++) s = s + q[i];
          if (q[0][7:0] != 8'hA5)                e_code = 1;
          else if (q[0][20] && s != q[15])       e_code = 2;
          else if (q[5][31] && !q[0][10])        e_code = 3;
          else                                   e_code = 0;
          e_status = 0;
          e_status[20:13] = q[0][7:0];
          e_status[4]  = q[0][11]; e_status[5]  = q[0][18];
          e_status[6]  = q[0][20]; e_status[7]  = q[0][19];
          e_status[8]  = q[0][21]; e_status[9]  = q[0][10];
          e_status[10] = q[5][31]; e_status[11] = q[0][9];
          e_status[12] = q[0][8];
          e_size   = q[3][17:0];
          e_stride = 18'(q[3][31:18] * 16);
          e_video  = (32'(q[3][17:0]) << 14) | 32'(q[3][31:18]);
          e_valid = 1; e_done = 1;
          q.delete();
        end
      end
    end
  end

  logic cmp_on = 0;
  always @(negedge clk) if (cmp_on) begin
    chk("R1 ready", 32'(in_ready), 1);
    chk("R1 done", 32'(res_done), 32'(e_done));
    chk("R8 valid", 32'(res_valid), 32'(e_valid));
    chk("R2 R3 R4 R5 code", 32'(res_code), 32'(e_code));
    chk("R6 status", res_status, e_status);
    chk("R7 video", res_video, e_video);
    chk("R7 size", 32'(res_line_size), 32'(e_size));
    chk("R7 stride", 32'(res_line_stride), 32'(e_stride));
  end

  function automatic desc_t mk(logic [31:0] ctrl, bit flag, logic [31:0] line,
                               bit sum_ok, int seed);
    desc_t w; logic [31:0] s;
    for (int i = 0; i < 16; i++) w[i] = (32'(i + seed) * 32'h9E3779B9) ^ 32'(seed);
    w[0] = ctrl; w[3] = line;
    w[5] = flag ? (w[5] | 32'h8000_0000) : (w[5] & 32'h7FFF_FFFF);
    s = 0;
    for (int i = 0; i < 15; i++) s = s + w[i];
    w[15] = sum_ok ? s : s + 1;
    return w;
  endfunction

  task automatic send(desc_t w, int gap, int abort_at);
    for (int i = 0; i < 16; i++) begin
      if (gap > 0 && (i % gap) == 1) begin
        in_valid = 0; @(negedge clk);
      end
      in_valid = 1; in_data = w[i];
      in_abort = (i == abort_at);
      @(negedge clk);
      in_abort = 0;
      if (i == abort_at) begin in_valid = 0; return; end
    end
    in_valid = 0; in_data = 32'hDEAD_BEEF;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; in_valid = 0; in_abort = 0; in_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 done", 32'(res_done), 0);
    chk("R10 valid", 32'(res_valid), 0);
    chk("R10 code", 32'(res_code), 0);
    chk("R10 status", res_status, 0);
    cmp_on = 1;
    // ok with checksum on, all status flags
    send(mk(32'h003F_0FA5, 0, 32'h1234_5678, 1, 1), 0, -1); @(negedge clk);
    chk("R4 ok code", 32'(res_code), 0);
    // R2 bad marker
    send(mk(32'h0000_00A4, 0, 32'h0004_0040, 1, 2), 0, -1); @(negedge clk);
    // R3 bad checksum
    send(mk(32'h0010_00A5, 0, 32'hFFFF_FFFF, 0, 3), 2, -1); @(negedge clk);
    chk("R3 sum code", 32'(res_code), 2);
    // R3 checksum disabled: mismatch ignored
    send(mk(32'h0000_00A5, 0, 32'h0, 0, 4), 0, -1); @(negedge clk);
    chk("R3 disabled code", 32'(res_code), 0);
    // R4 done flag stale, then overridden
    send(mk(32'h0010_00A5, 1, 32'h8000_0001, 1, 5), 3, -1); @(negedge clk);
    chk("R4 done code", 32'(res_code), 3);
    send(mk(32'h0010_04A5, 1, 32'h8000_0001, 1, 6), 0, -1); @(negedge clk);
    chk("R4 ignore code", 32'(res_code), 0);
    // R5 priority pairs
    send(mk(32'h0010_005A, 1, 32'h1, 0, 7), 0, -1); @(negedge clk);
    chk("R5 marker over sum", 32'(res_code), 1);
    send(mk(32'h0010_00A5, 1, 32'h2, 0, 8), 0, -1);
    chk("R5 sum over done", 32'(res_code), 2);
    // R8 back-to-back: first word of next clears results
    send(mk(32'h0000_01A5, 0, 32'h7, 1, 9), 0, -1);
    // R9 abort part way, then a clean descriptor
    send(mk(32'h0000_00A5, 0, 32'h3, 1, 10), 0, 7);
    repeat (4) @(negedge clk);
    chk("R9 no done after abort", 32'(res_done), 0);
    chk("R9 no valid after abort", 32'(res_valid), 0);
    send(mk(32'h0030_02A5, 1, 32'hABCD_EF01, 1, 11), 1, -1); @(negedge clk);
    chk("R9 clean after abort", 32'(res_code), 3);
    repeat (3) @(negedge clk);
    cmp_on = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule